// File: doc/BRIEF.md
# Serial Port Routing and Sleep Source Selector

This block decides which of two serial ports, a UART or an SPI target port, carries the outbound data stream. It also decides which pin, if any, controls the device's sleep state. The routing choice is made once per reset. It combines two port-enable configuration bits with two active-low strap pins, all of which are read while reset is held. After reset, the only change the block allows is a single, irreversible hand-over from the UART to SPI. This hand-over happens when both ports are enabled and the SPI port receives its first byte. A strap can force SPI on at once. In that case the block emits a single-cycle pulse just after reset so that a status byte can be queued, which in turn raises the port's attention line. A second strap forces a default UART setup in command mode, and it overrides everything else.

The sleep selector is independent of the routing choice. A dedicated sleep-request pin controls sleep when its enable bit is set. Otherwise the SPI select line controls sleep when its enable bit is set. When neither is enabled, the device never sleeps. Both pins are asynchronous, so each passes through a synchronizer of `SYNC_STAGES` flops before the registered `awake` output.

All ports are plain control and status levels or pulses. There is no streaming interface, so no valid/ready handshake applies.

Top module: `serial_port_arbiter`

## Requirements
- R1: While `rst_n` is low, `route_spi`, `uart_en`, `force_uart_dflt` and `spi_status_pulse` are 0 and `awake` is 1 from the first clock edge onward.
- R2: Straps and port-enable bits are taken at the last rising clock edge with `rst_n` low; changes to them after reset is released have no effect on routing until the next reset.
- R3: With both ports enabled and both straps high, `uart_en`=1 and `route_spi`=0 after reset until the edge that samples `spi_rx_first`=1; from the next cycle `route_spi`=1 and `uart_en`=0.
- R4: Once `route_spi` is 1 it stays 1 until the next reset; further `spi_rx_first` pulses change nothing.
- R5: `strap_spi_force_n`=0 (with `strap_uart_rescue_n`=1) at reset gives `route_spi`=1 and `uart_en`=0 from the first cycle after release, whatever the enable bits.
- R6: `spi_status_pulse` is 1 for exactly one cycle, the first cycle after reset release, and only when SPI was forced by strap.
- R7: `strap_uart_rescue_n`=0 at reset gives `force_uart_dflt`=1, `uart_en`=1 and `route_spi`=0 until the next reset. This wins over the SPI strap and over the enable bits, and `spi_rx_first` is ignored.
- R8: With only SPI enabled and both straps high, `route_spi`=1 from the first cycle after release, with no status pulse.
- R9: With SPI not enabled and both straps high, the UART is used (`uart_en`=1), and `spi_rx_first` is ignored.
- R10: After the first cycle following release, exactly one of `route_spi` and `uart_en` is 1.
- R11: With `cfg_slp_pin_en`=1, `awake` is the inverse of `slp_req` (1 requests sleep), `SYNC_STAGES`+1 cycles after the pin changes.
- R12: With `cfg_slp_pin_en`=0 and `cfg_sel_slp_en`=1, `spi_sel_n`=0 keeps the device awake and `spi_sel_n`=1 puts it to sleep, with the same latency.
- R13: With both sleep enable bits 0, `awake` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are read while low |
| cfg_uart_en | input | 1 | UART port enabled in configuration |
| cfg_spi_en | input | 1 | SPI port enabled in configuration |
| strap_spi_force_n | input | 1 | Strap, low at reset forces SPI mode |
| strap_uart_rescue_n | input | 1 | Strap, low at reset forces default UART in command mode |
| spi_rx_first | input | 1 | Pulse: a byte was received on the SPI port |
| spi_sel_n | input | 1 | SPI select line, asynchronous, active low |
| slp_req | input | 1 | Sleep-request pin, asynchronous, 1 requests sleep |
| cfg_slp_pin_en | input | 1 | Sleep-request pin controls sleep |
| cfg_sel_slp_en | input | 1 | SPI select may control sleep |
| route_spi | output | 1 | Outbound data goes to SPI |
| uart_en | output | 1 | UART port enabled |
| force_uart_dflt | output | 1 | Default UART setup and command mode forced |
| spi_status_pulse | output | 1 | One-cycle request to queue a status byte |
| awake | output | 1 | 1 awake, 0 asleep |

## Verification
A wrong mode register would show on `route_spi`, `uart_en` and `force_uart_dflt` in the very first cycle after reset release. The exception is the shared mode, where a missed or premature hand-over only appears in the cycle after an `spi_rx_first` pulse, or after a pulse that should have been ignored. A lost status pulse or a doubled one is visible only in the two cycles after release. A wrong sleep source, or a wrong synchronizer depth, shows on `awake` exactly `SYNC_STAGES`+1 edges after a pin toggles. For that reason the reference model is compared on every cycle, not only at the end of a scenario.

// File: rtl/serial_port_arbiter_pkg.sv
package serial_port_arbiter_pkg;
  typedef enum logic [2:0] {
    RT_UART_ONLY   = 3'd0,
    RT_SHARED_UART = 3'd1,
    RT_SPI_CFG     = 3'd2,
    RT_SPI_STRAP   = 3'd3,
    RT_UART_RESCUE = 3'd4
  } route_mode_t;

  function automatic route_mode_t pick_mode(input logic rescue_n, input logic force_n,
                                            input logic uart_on, input logic spi_on);
    if (!rescue_n)               return RT_UART_RESCUE;
    else if (!force_n)           return RT_SPI_STRAP;
    else if (spi_on && !uart_on) return RT_SPI_CFG;
    else if (spi_on && uart_on)  return RT_SHARED_UART;
    else                         return RT_UART_ONLY;
  endfunction
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/route_fsm.sv
module route_fsm
  import serial_port_arbiter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_uart_en,
  input  logic cfg_spi_en,
  input  logic strap_spi_force_n,
  input  logic strap_uart_rescue_n,
  input  logic spi_rx_first,
  output logic route_spi,
  output logic uart_en,
  output logic force_uart_dflt,
  output logic spi_status_pulse
);
  route_mode_t mode_q;
  logic        live_q;
  logic        pulse_q;

  // While reset is held the decision register tracks the pins, so the
  // value present at the last reset edge is the one kept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= pick_mode(strap_uart_rescue_n, strap_spi_force_n, cfg_uart_en, cfg_spi_en);
      live_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      live_q  <= 1'b1;
      pulse_q <= (mode_q == RT_SPI_STRAP) && !live_q;
      if (mode_q == RT_SHARED_UART && live_q && spi_rx_first)
        mode_q <= RT_SPI_CFG;
    end
  end

  always_comb begin
    route_spi       = live_q && (mode_q == RT_SPI_CFG || mode_q == RT_SPI_STRAP);
    uart_en         = live_q && !(mode_q == RT_SPI_CFG || mode_q == RT_SPI_STRAP);
    force_uart_dflt = live_q && (mode_q == RT_UART_RESCUE);
  end

  assign spi_status_pulse = pulse_q;
endmodule

// File: rtl/sleep_select.sv
module sleep_select (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_req_s,
  input  logic sel_n_s,
  input  logic cfg_slp_pin_en,
  input  logic cfg_sel_slp_en,
  output logic awake
);
  logic awake_d;

  always_comb begin
    if (cfg_slp_pin_en)      awake_d = !slp_req_s;
    else if (cfg_sel_slp_en) awake_d = !sel_n_s;
    else                     awake_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) awake <= 1'b1;
    else        awake <= awake_d;
  end
endmodule

// File: rtl/serial_port_arbiter.sv
module serial_port_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_uart_en,
  input  logic cfg_spi_en,
  input  logic strap_spi_force_n,
  input  logic strap_uart_rescue_n,
  input  logic spi_rx_first,
  input  logic spi_sel_n,
  input  logic slp_req,
  input  logic cfg_slp_pin_en,
  input  logic cfg_sel_slp_en,
  output logic route_spi,
  output logic uart_en,
  output logic force_uart_dflt,
  output logic spi_status_pulse,
  output logic awake
);
  logic sel_n_s;
  logic slp_req_s;

  sig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(spi_sel_n), .q(sel_n_s)
  );

  sig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_slp_sync (
    .clk(clk), .rst_n(rst_n), .d(slp_req), .q(slp_req_s)
  );

  route_fsm i_route (
    .clk(clk), .rst_n(rst_n),
    .cfg_uart_en(cfg_uart_en), .cfg_spi_en(cfg_spi_en),
    .strap_spi_force_n(strap_spi_force_n), .strap_uart_rescue_n(strap_uart_rescue_n),
    .spi_rx_first(spi_rx_first),
    .route_spi(route_spi), .uart_en(uart_en),
    .force_uart_dflt(force_uart_dflt), .spi_status_pulse(spi_status_pulse)
  );

  sleep_select i_sleep (
    .clk(clk), .rst_n(rst_n),
    .slp_req_s(slp_req_s), .sel_n_s(sel_n_s),
    .cfg_slp_pin_en(cfg_slp_pin_en), .cfg_sel_slp_en(cfg_sel_slp_en),
    .awake(awake)
  );
endmodule

// File: rtl/serial_port_arbiter_chk.sv
module serial_port_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_slp_pin_en,
  input logic cfg_sel_slp_en,
  input logic route_spi,
  input logic uart_en,
  input logic force_uart_dflt,
  input logic spi_status_pulse,
  input logic awake
);
  // R10: after release exactly one port carries the outbound stream
  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (route_spi ^ uart_en));

  // R4: the hand-over to SPI is never undone while out of reset
  a_r4_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(route_spi)) |-> route_spi);

  // R6: status pulse lasts one cycle and only follows reset release
  a_r6_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    spi_status_pulse |=> !spi_status_pulse);

  a_r6_pulse_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    spi_status_pulse |-> (!$past(rst_n, 2) && route_spi));

  // R7: forced default UART always keeps the UART path
  a_r7_rescue_uart: assert property (@(posedge clk) disable iff (!rst_n)
    force_uart_dflt |-> (uart_en && !route_spi));

  // R13: no sleep source enabled means always awake
  a_r13_never_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_slp_pin_en && !cfg_sel_slp_en
     && $past(!cfg_slp_pin_en && !cfg_sel_slp_en)) |-> awake);
endmodule

bind serial_port_arbiter serial_port_arbiter_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_slp_pin_en(cfg_slp_pin_en), .cfg_sel_slp_en(cfg_sel_slp_en),
  .route_spi(route_spi), .uart_en(uart_en), .force_uart_dflt(force_uart_dflt),
  .spi_status_pulse(spi_status_pulse), .awake(awake)
);

// File: tb/test_serial_port_arbiter.sv
module test_serial_port_arbiter;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_uart_en = 1'b1, cfg_spi_en = 1'b1;
  logic strap_spi_force_n = 1'b1, strap_uart_rescue_n = 1'b1;
  logic spi_rx_first = 1'b0, spi_sel_n = 1'b1, slp_req = 1'b0;
  logic cfg_slp_pin_en = 1'b0, cfg_sel_slp_en = 1'b0;
  logic route_spi, uart_en, force_uart_dflt, spi_status_pulse, awake;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag_rt = "R1";
  string tag_sl = "R1";

  // reference model state
  int m_mode = 0;   // 0 uart,1 shared,2 spi after switch/cfg,3 spi strap,4 rescue
  bit m_live = 0, m_pulse = 0, m_awake = 1;
  bit sel_q[$];
  bit slp_q[$];

  always #5 clk = ~clk;

  serial_port_arbiter #(.SYNC_STAGES(SYNC)) i_serial_port_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_uart_en(cfg_uart_en), .cfg_spi_en(cfg_spi_en),
    .strap_spi_force_n(strap_spi_force_n), .strap_uart_rescue_n(strap_uart_rescue_n),
    .spi_rx_first(spi_rx_first), .spi_sel_n(spi_sel_n), .slp_req(slp_req),
    .cfg_slp_pin_en(cfg_slp_pin_en), .cfg_sel_slp_en(cfg_sel_slp_en),
    .route_spi(route_spi), .uart_en(uart_en), .force_uart_dflt(force_uart_dflt),
    .spi_status_pulse(spi_status_pulse), .awake(awake)
  );

  task automatic model_update();
    bit old_sel, old_slp;
    if (!rst_n) begin
      if (!strap_uart_rescue_n)            m_mode = 4;
      else if (!strap_spi_force_n)         m_mode = 3;
      else if (cfg_spi_en && !cfg_uart_en) m_mode = 2;
      else if (cfg_spi_en)                 m_mode = 1;
      else                                 m_mode = 0;
      m_live = 0; m_pulse = 0; m_awake = 1;
      sel_q.delete(); slp_q.delete();
      for (int i = 0; i < SYNC; i++) begin sel_q.push_back(1'b1); slp_q.push_back(1'b0); end
    end else begin
      m_pulse = (m_mode == 3) && !m_live;
      if (m_mode == 1 && m_live && spi_rx_first) m_mode = 2;
      m_live = 1;
      old_sel = sel_q[SYNC-1];
      old_slp = slp_q[SYNC-1];
      if (cfg_slp_pin_en)      m_awake = !old_slp;
      else if (cfg_sel_slp_en) m_awake = !old_sel;
      else                     m_awake = 1'b1;
      void'(sel_q.pop_back()); sel_q.push_front(spi_sel_n);
      void'(slp_q.pop_back()); slp_q.push_front(slp_req);
    end
  endtask

  task automatic check1(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_route;
    e_route = m_live && (m_mode == 2 || m_mode == 3);
    check1(tag_rt, "route_spi", route_spi, e_route);
    check1(tag_rt, "uart_en", uart_en, m_live && !e_route);
    check1(tag_rt, "force_uart_dflt", force_uart_dflt, m_live && m_mode == 4);
    check1(tag_rt, "spi_status_pulse", spi_status_pulse, m_pulse);
    check1(tag_sl, "awake", awake, m_awake);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
    end
  endtask

  // R2: straps and enables are flipped right after release to prove they are ignored
  task automatic do_reset(bit u, bit s, bit force_n, bit rescue_n);
    rst_n = 0; cfg_uart_en = u; cfg_spi_en = s;
    strap_spi_force_n = force_n; strap_uart_rescue_n = rescue_n;
    tag_rt = "R1"; tag_sl = "R1";
    step(4);
    rst_n = 1;
    strap_spi_force_n = !force_n; strap_uart_rescue_n = !rescue_n;
    cfg_uart_en = !u; cfg_spi_en = !s;
  endtask

  task automatic rx_pulse();
    spi_rx_first = 1; step(1); spi_rx_first = 0;
  endtask

  initial begin
    @(negedge clk);
    // R3 R4 R2: shared mode hand-over
    do_reset(1, 1, 1, 1);
    tag_rt = "R2"; tag_sl = "R13";
    step(3);
    tag_rt = "R3";
    step(2);
    rx_pulse();
    step(1);
    check1("R3", "route_spi after first rx", route_spi, 1'b1);
    tag_rt = "R4";
    rx_pulse(); step(3);
    check1("R4", "uart_en stays off", uart_en, 1'b0);

    // R5 R6: SPI forced by strap
    do_reset(1, 0, 0, 1);
    tag_rt = "R6"; step(1);
    check1("R6", "pulse first cycle", spi_status_pulse, 1'b1);
    tag_rt = "R5"; step(1);
    check1("R6", "pulse gone", spi_status_pulse, 1'b0);
    step(4);

    // R7: rescue strap wins over force strap
    do_reset(1, 1, 0, 0);
    tag_rt = "R7"; step(2);
    check1("R7", "force_uart_dflt", force_uart_dflt, 1'b1);
    rx_pulse(); step(3);

    // R8: SPI only by configuration
    do_reset(0, 1, 1, 1);
    tag_rt = "R8"; step(1);
    check1("R8", "route_spi", route_spi, 1'b1);
    check1("R8", "no pulse", spi_status_pulse, 1'b0);
    step(3);

    // R9 R10: UART only and nothing enabled
    do_reset(1, 0, 1, 1);
    tag_rt = "R9"; step(2); rx_pulse(); step(3);
    check1("R10", "uart_en", uart_en, 1'b1);
    do_reset(0, 0, 1, 1);
    tag_rt = "R9"; step(2); rx_pulse(); step(2);

    // R11: sleep-request pin
    cfg_slp_pin_en = 1; cfg_sel_slp_en = 1; tag_sl = "R11";
    step(2);
    slp_req = 1; step(SYNC + 1);
    check1("R11", "asleep", awake, 1'b0);
    spi_sel_n = 0; step(3);
    slp_req = 0; step(1); slp_req = 1; step(1); slp_req = 0; step(SYNC + 2);
    check1("R11", "awake again", awake, 1'b1);

    // R12: select line as sleep pin
    cfg_slp_pin_en = 0; tag_sl = "R12";
    spi_sel_n = 1; step(SYNC + 1);
    check1("R12", "select high sleeps", awake, 1'b0);
    slp_req = 1;
    spi_sel_n = 0; step(SYNC + 1);
    check1("R12", "select low wakes", awake, 1'b1);
    spi_sel_n = 1; step(4);

    // R13: no sleep source
    cfg_sel_slp_en = 0; tag_sl = "R13";
    step(2);
    slp_req = 0; spi_sel_n = 0; step(2); spi_sel_n = 1; slp_req = 1; step(4);
    check1("R13", "never sleeps", awake, 1'b1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule